// File: doc/BRIEF.md
# Paged Microcode Register Window

This block is the host-side slave front end of a small microcoded vector coprocessor. It takes single-cycle 32-bit word accesses on a plain select/write-enable bus and sorts each word address into one of four regions:
- a pair of control registers (the run control/status word and the code-page selector);
- a 128-entry general register window;
- a 512-word microcode window;
- everything else, which is unmapped.

For the two storage windows it produces write strobes, an index into the external storage and a copy of the write data. It also folds the storage read data into a registered read bus.

The microcode store holds 2048 words, four times the size of its window. A 2-bit code-page register selects which quarter of the store the window currently shows.

Writing the run control word with bit 0 set starts a run. The block then emits a one-cycle start pulse and holds busy until the sequencer returns a done pulse. While busy is set, host writes into the general registers and the microcode are suppressed.

Top module: `ucode_window`

## Requirements
- R1: After reset, busy and the code page are 0, and bus_rdata, bus_err, run_start, gpr_we and uc_we are all low.
- R2: An access to word address 0x100+i (0 ≤ i ≤ 127) drives gpr_idx = i. A write in that range raises gpr_we in the same cycle. A read returns gpr_rdata on bus_rdata in the following cycle.
- R3: An access to word address 0x200+k (0 ≤ k ≤ 511) drives uc_idx = 512·page + k. A write in that range raises uc_we in the same cycle. A read returns uc_rdata in the following cycle.
- R4: Word address 0x001 is the code-page register. A write keeps only bits 1:0 of the data. A read returns the page in bits 1:0 and zeros above.
- R5: A write to word address 0x000 with data bit 0 = 1 while idle sets busy. It also produces run_start high for exactly the one cycle after the write.
- R6: Reading word address 0x000 returns busy in bit 0 and zeros above. A run_done pulse clears busy. Writing 0x000 with bit 0 = 0 has no effect.
- R7: While busy is set, writes to the general register and microcode windows leave gpr_we and uc_we low. A further start write produces no run_start.
- R8: An access to any other address reads as zero, raises no write strobe, and sets bus_err for one cycle in the cycle after the access.
- R9: bus_rdata is zero in any cycle that does not follow a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Unmapped-access strobe, registered |
| gpr_we | output | 1 | General register write strobe |
| gpr_idx | output | 7 | General register index |
| gpr_rdata | input | 32 | General register read data (asynchronous) |
| uc_we | output | 1 | Microcode write strobe |
| uc_idx | output | 11 | Microcode store index (page translated) |
| uc_rdata | input | 32 | Microcode read data (asynchronous) |
| st_wdata | output | 32 | Write data toward both stores |
| run_start | output | 1 | One-cycle run start pulse |
| run_done | input | 1 | Sequencer done pulse, clears busy |

## Verification
The write strobes and both storage indices are combinational, so the bench samples them one time unit after it drives an access, before the capturing edge. bus_rdata, bus_err and run_start each carry one register, so they are sampled at the falling edge that follows the edge that captured the access. A second sample one cycle later confirms that the strobes fall back and that read data returns to zero. Expected read values come from the bench's own storage models, indexed by its own page arithmetic.

// File: rtl/ucwin_pkg.sv
package ucwin_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int GPR_N    = 128;
  localparam int GPR_BASE = 'h100;
  localparam int UC_WIN   = 512;
  localparam int UC_BASE  = 'h200;
  localparam int PAGE_W   = 2;
  localparam int CTL_ADDR  = 'h000;
  localparam int PAGE_ADDR = 'h001;
  localparam int GPR_IDX_W = $clog2(GPR_N);
  localparam int UC_OFF_W  = $clog2(UC_WIN);
  localparam int UC_IDX_W  = UC_OFF_W + PAGE_W;

  typedef enum logic [2:0] {
    RG_CTL, RG_PAGE, RG_GPR, RG_UC, RG_NONE
  } region_e;

  function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
    int ai;
    ai = int'(a);
    if (ai == CTL_ADDR)                                return RG_CTL;
    else if (ai == PAGE_ADDR)                          return RG_PAGE;
    else if (ai >= GPR_BASE && ai < GPR_BASE + GPR_N)  return RG_GPR;
    else if (ai >= UC_BASE && ai < UC_BASE + UC_WIN)   return RG_UC;
    else                                               return RG_NONE;
  endfunction

  function automatic logic [UC_IDX_W-1:0] uc_index(
      input logic [PAGE_W-1:0] pg, input logic [ADDR_W-1:0] a);
    int full;
    full = int'(pg) * UC_WIN + (int'(a) - UC_BASE);
    return UC_IDX_W'(full);
  endfunction
endpackage

// File: rtl/ucwin_decode.sv
module ucwin_decode
  import ucwin_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                busy,
  input  logic [PAGE_W-1:0]   page,
  output region_e             region,
  output logic                ctl_we,
  output logic                page_we,
  output logic                gpr_we,
  output logic                uc_we,
  output logic                bad_acc,
  output logic [GPR_IDX_W-1:0] gpr_idx,
  output logic [UC_IDX_W-1:0]  uc_idx
);
  logic wr_any;

  assign region  = decode_region(addr);
  assign wr_any  = sel && we;
  assign ctl_we  = wr_any && (region == RG_CTL);
  assign page_we = wr_any && (region == RG_PAGE);
  assign gpr_we  = wr_any && (region == RG_GPR) && !busy;
  assign uc_we   = wr_any && (region == RG_UC) && !busy;
  assign bad_acc = sel && (region == RG_NONE);
  assign gpr_idx = GPR_IDX_W'(int'(addr) - GPR_BASE);
  assign uc_idx  = uc_index(page, addr);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_we, page_we, gpr_we, uc_we}));
endmodule

// File: rtl/ucwin_ctl.sv
module ucwin_ctl
  import ucwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              page_we,
  input  logic              go_bit,
  input  logic [PAGE_W-1:0] page_bits,
  input  logic              run_done,
  output logic              busy,
  output logic [PAGE_W-1:0] page,
  output logic              run_start
);
  logic start_req;

  assign start_req = ctl_we && go_bit && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      page      <= '0;
      run_start <= 1'b0;
    end else begin
      run_start <= start_req;
      if (start_req)     busy <= 1'b1;
      else if (run_done) busy <= 1'b0;
      if (page_we) page <= page_bits;
    end
  end

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> busy);
  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);
endmodule

// File: rtl/ucwin_rdmux.sv
module ucwin_rdmux
  import ucwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  region_e           region,
  input  logic              bad_acc,
  input  logic              busy,
  input  logic [PAGE_W-1:0] page,
  input  logic [DATA_W-1:0] gpr_rdata,
  input  logic [DATA_W-1:0] uc_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic [DATA_W-1:0] mux_d;

  always_comb begin
    unique case (region)
      RG_CTL:  mux_d = {{(DATA_W-1){1'b0}}, busy};
      RG_PAGE: mux_d = {{(DATA_W-PAGE_W){1'b0}}, page};
      RG_GPR:  mux_d = gpr_rdata;
      RG_UC:   mux_d = uc_rdata;
      default: mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rd_en ? mux_d : '0;
      err   <= bad_acc;
    end
  end
endmodule

// File: rtl/ucode_window.sv
module ucode_window
  import ucwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic                 gpr_we,
  output logic [GPR_IDX_W-1:0] gpr_idx,
  input  logic [DATA_W-1:0]    gpr_rdata,
  output logic                 uc_we,
  output logic [UC_IDX_W-1:0]  uc_idx,
  input  logic [DATA_W-1:0]    uc_rdata,
  output logic [DATA_W-1:0]    st_wdata,
  output logic                 run_start,
  input  logic                 run_done
);
  region_e           region;
  logic              ctl_we, page_we, bad_acc, busy;
  logic [PAGE_W-1:0] page;

  assign st_wdata = bus_wdata;

  ucwin_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .busy(busy), .page(page), .region(region), .ctl_we(ctl_we),
    .page_we(page_we), .gpr_we(gpr_we), .uc_we(uc_we), .bad_acc(bad_acc),
    .gpr_idx(gpr_idx), .uc_idx(uc_idx)
  );

  ucwin_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .page_we(page_we),
    .go_bit(bus_wdata[0]), .page_bits(bus_wdata[PAGE_W-1:0]),
    .run_done(run_done), .busy(busy), .page(page), .run_start(run_start)
  );

  ucwin_rdmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_sel && !bus_we), .region(region),
    .bad_acc(bad_acc), .busy(busy), .page(page), .gpr_rdata(gpr_rdata),
    .uc_rdata(uc_rdata), .rdata(bus_rdata), .err(bus_err)
  );

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!gpr_we && !uc_we));
  // R3
  page_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_we |-> (uc_idx[UC_IDX_W-1 -: PAGE_W] == page));
  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
endmodule

// File: tb/sim_ucode_window.sv
module sim_ucode_window;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, run_done = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, gpr_rdata, uc_rdata, st_wdata;
  logic        bus_err, gpr_we, uc_we, run_start;
  logic [6:0]  gpr_idx;
  logic [10:0] uc_idx;

  logic [31:0] gpr_mem [128];
  logic [31:0] uc_mem  [2048];
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_window u0 (.*);

  assign gpr_rdata = gpr_mem[gpr_idx];
  assign uc_rdata  = uc_mem[uc_idx];
  always @(posedge clk) begin
    if (gpr_we) gpr_mem[gpr_idx] <= st_wdata;
    if (uc_we)  uc_mem[uc_idx]   <= st_wdata;
  end

  // {is_read, addr, wdata, expected read data}
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 10'h001, 32'hFFFF_FFFE, 32'h0},
    {1'b1, 10'h001, 32'h0, 32'h0000_0002},
    {1'b0, 10'h205, 32'hA5A5_0001, 32'h0},
    {1'b0, 10'h105, 32'h1234_5678, 32'h0},
    {1'b1, 10'h105, 32'h0, 32'h1234_5678},
    {1'b1, 10'h205, 32'h0, 32'hA5A5_0001},
    {1'b0, 10'h001, 32'h0000_0003, 32'h0},
    {1'b0, 10'h3FF, 32'hCAFE_F00D, 32'h0},
    {1'b1, 10'h3FF, 32'h0, 32'hCAFE_F00D},
    {1'b0, 10'h001, 32'h0, 32'h0},
    {1'b1, 10'h205, 32'h0, 32'h0},
    {1'b1, 10'h17F, 32'h0, 32'h0},
    {1'b1, 10'h000, 32'h0, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at falling edge, release at next falling edge (registered results valid then)
  task automatic drive(input bit we, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
  endtask
  task automatic release_bus();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [10:0] exp_uc(input int pg, input int a);
    return 11'((pg << 9) + (a - 'h200));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pg;
    for (int i = 0; i < 128; i++) gpr_mem[i] = '0;
    for (int i = 0; i < 2048; i++) uc_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_rdata == 0 && !bus_err && !run_start, "R1 outputs", bus_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!gpr_we && !uc_we, "R1 strobes", {gpr_we, uc_we}, 0);

    pg = 0;
    for (int v = 0; v < NV; v++) begin
      logic rd; logic [9:0] a; logic [31:0] d, e;
      {rd, a, d, e} = VEC[v];
      drive(!rd, a, d);
      if (a >= 10'h200) chk(uc_idx == exp_uc(pg, int'(a)), "R3 uc_idx", 32'(uc_idx), 32'(exp_uc(pg, int'(a))));
      if (a >= 10'h100 && a < 10'h180) chk(gpr_idx == 7'(a - 10'h100), "R2 gpr_idx", 32'(gpr_idx), 32'(a - 10'h100));
      if (a == 10'h001 && !rd) pg = int'(d[1:0]);
      release_bus();
      if (rd) chk(bus_rdata == e, "R2/R3/R4 read vector", bus_rdata, e);
      else    chk(bus_rdata == 0, "R9 idle rdata", bus_rdata, 0);
    end

    // R5 start pulse
    drive(1'b1, 10'h000, 32'h1);
    release_bus();
    chk(run_start == 1'b1, "R5 start high", 32'(run_start), 1);
    @(negedge clk);
    chk(run_start == 1'b0, "R5 start one cycle", 32'(run_start), 0);
    drive(1'b0, 10'h000, 0);
    release_bus();
    chk(bus_rdata == 32'h1, "R6 busy readback", bus_rdata, 1);

    // R7 writes blocked while busy
    drive(1'b1, 10'h110, 32'hDEAD_BEEF);
    chk(!gpr_we, "R7 gpr_we busy", 32'(gpr_we), 0);
    release_bus();
    drive(1'b1, 10'h210, 32'hDEAD_BEEF);
    chk(!uc_we, "R7 uc_we busy", 32'(uc_we), 0);
    release_bus();
    drive(1'b1, 10'h000, 32'h1);
    release_bus();
    chk(!run_start, "R7 no restart", 32'(run_start), 0);
    drive(1'b1, 10'h000, 32'h0);
    release_bus();
    drive(1'b0, 10'h000, 0);
    release_bus();
    chk(bus_rdata == 32'h1, "R6 write 0 no effect", bus_rdata, 1);

    // R6 done clears busy
    @(negedge clk); run_done = 1'b1;
    @(negedge clk); run_done = 1'b0;
    drive(1'b0, 10'h000, 0);
    release_bus();
    chk(bus_rdata == 32'h0, "R6 done clears busy", bus_rdata, 0);
    drive(1'b0, 10'h110, 0);
    release_bus();
    chk(bus_rdata == 32'h0, "R7 blocked gpr unchanged", bus_rdata, 0);
    drive(1'b1, 10'h000, 32'h0);
    release_bus();
    chk(!run_start, "R6 write 0 no start", 32'(run_start), 0);

    // R8 unmapped
    drive(1'b0, 10'h050, 0);
    release_bus();
    chk(bus_err && bus_rdata == 0, "R8 unmapped read", bus_rdata, 0);
    @(negedge clk);
    chk(!bus_err, "R8 err one cycle", 32'(bus_err), 0);
    drive(1'b1, 10'h180, 32'h5555_5555);
    chk(!gpr_we && !uc_we, "R8 no strobe", {gpr_we, uc_we}, 0);
    release_bus();
    chk(bus_err, "R8 unmapped write err", 32'(bus_err), 1);
    drive(1'b1, 10'h002, 32'h3);
    release_bus();
    drive(1'b0, 10'h001, 0);
    release_bus();
    chk(bus_rdata == 32'h0 && !bus_err, "R8 write ignored page", bus_rdata, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule